// File: doc/BRIEF.md
# Machine-Mode Performance Counter Bank

The block keeps a set of up to 32 wide counter slots for machine-mode performance monitoring. Slot 0 counts clock cycles and slot 2 counts retire pulses. Slots 3 and up are programmable. Each one counts the cycles in which one line of an event vector is high, and a per-slot selector register chooses that line. Slot 1 is the real-time counter, which is not held here and reads zero.

Two control registers sit beside the counters. The stop register freezes chosen counters. The delegation register records which counters code at lower privilege may read. Compile-time masks decide which slots exist and which control bits are writable. A bit for a missing or disallowed slot reads zero and ignores writes. A selector only accepts codes from a configured legal set.

Software reaches every register through one combinational-read, single-cycle-write CSR port. Address bits [6:5] pick the region: 0 for counters, 1 for selectors, 2 for control. Bits [4:0] pick the slot. In the control region, index 0 is the stop register and index 1 is the delegation register.

Top module: `perf_counter_bank`

## Requirements
- R1: After a synchronous active-low reset, every counter, selector, stop bit and delegation bit reads zero.
- R2: The cycle counter (slot 0) adds one on every clock while its stop bit is clear. Setting a slot's stop bit freezes that slot from the next clock on. Clearing the bit resumes counting from the clock after the write.
- R3: The retire counter (slot 2) adds one on every clock where the retire input is high and stop bit 2 is clear.
- R4: A programmable slot adds one on each clock where event_vec[code] is high, with code being its selector value. Code 0 counts nothing, even if event_vec[0] is high.
- R5: A selector write is accepted only if the written value is below 2**EVT_W and its bit is set in the legal mask. Code 0 is always legal. The default mask 0x00BF makes codes 1-5 and 7 legal. Any other write leaves the selector unchanged.
- R6: A stop bit is writable only for a present slot whose bit is allowed. Bit 1 is always zero. With the defaults (base set on, programmable set on, slots 3-6 present, all stop bits allowed), writing all ones reads back 0x7D.
- R7: A delegation bit is writable for slots 0-2 when the base set is present, and for present programmable slots, in both cases only if allowed. With the defaults (slot 4 not delegable), writing all ones reads back 0x6F.
- R8: A CSR write to a counter takes priority over that counter's increment in the same clock. The written value is read back exactly.
- R9: Counters and selectors of absent slots (slot 1 and slots 7-31 by default) read zero and ignore writes.
- R10: Counters are CNT_W bits wide (64 by default) and wrap from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| event_vec | input | 2**EVT_W | Per-cycle event lines, indexed by selector code |
| retire | input | 1 | One pulse per retired instruction |
| csr_we | input | 1 | Write strobe |
| csr_addr | input | SLOT_W+2 | Region in [6:5], slot or control index in [4:0] |
| csr_wdata | input | CNT_W | Write data |
| csr_rdata | output | CNT_W | Combinational read data |

## Verification
On every cycle, the assertions check the following:
- A written counter holds the written value on the next clock.
- An incremented counter moves by exactly one, and an idle counter stays still.
- A rejected selector write changes nothing.
- Control registers follow their write masks.
- Stop bit 0 freezes the cycle counter.
- Absent slots and stop bit 1 read zero.

Only the bench scenarios can show the rest. That covers the exact counts under chosen event patterns, the timing of when a stop takes effect and when counting resumes, which codes the legal mask accepts, the default mask values, and the wrap from all ones.

// File: rtl/pcb_pkg.sv
// Package: shared constants and region encoding for the performance counter bank.
// Assumes: slot index width of 5 bits at the top level (up to 32 slots).
package pcb_pkg;
    typedef enum logic [1:0] {
        RG_CNT = 2'b00,
        RG_SEL = 2'b01,
        RG_CTL = 2'b10,
        RG_NONE = 2'b11
    } region_e;

    localparam int SLOT_CYCLE  = 0;
    localparam int SLOT_RTC    = 1;
    localparam int SLOT_RETIRE = 2;
    localparam int FIRST_PROG  = 3;

    localparam int CTL_STOP = 0;
    localparam int CTL_DELEG = 1;
endpackage

// File: rtl/pcb_counter.sv
// Module: one wide counter slot. A write loads the value and wins over the
// increment request in the same clock; otherwise inc adds one with wrap.
// Assumes: inc and we come from the same clock domain.
module pcb_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_q;

    // Purpose: load on write, otherwise count when requested.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (we)     cnt_q <= wdata;
        else if (inc)    cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> cnt == $past(wdata)); // R8
    AST_INC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !we) |=> cnt == $past(cnt) + 1'b1); // R10
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !we) |=> $stable(cnt)); // R2
endmodule

// File: rtl/pcb_evsel.sv
// Module: event selector for one programmable slot. Accepts only legal codes;
// code 0 is always legal and means no event.
// Assumes: in_range is low when the written value exceeds the code width.
module pcb_evsel #(
    parameter int EVT_W = 4,
    parameter logic [(1<<EVT_W)-1:0] LEGAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             in_range,
    input  logic [EVT_W-1:0] code,
    output logic [EVT_W-1:0] sel
);
    logic [EVT_W-1:0] sel_q;
    logic             accept;

    // Purpose: decide whether the offered code may be stored.
    always_comb accept = in_range && ((code == '0) || LEGAL[code]);

    // Purpose: hold the selected event code.
    always_ff @(posedge clk) begin
        if (!rst_n)              sel_q <= '0;
        else if (we && accept)   sel_q <= code;
    end

    assign sel = sel_q;

    AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !(in_range && ((code == '0) || LEGAL[code]))) |=> $stable(sel)); // R5
    AST_SEL_ALWAYS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) || LEGAL[sel]); // R5
endmodule

// File: rtl/pcb_mask_reg.sv
// Module: control register whose writable bits are fixed at compile time;
// bits outside the mask stay zero.
// Assumes: WMASK is a constant.
module pcb_mask_reg #(
    parameter int W = 32,
    parameter logic [W-1:0] WMASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;

    // Purpose: store only the writable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)  q_r <= '0;
        else if (we) q_r <= wdata & WMASK;
    end

    assign q = q_r;

    AST_MASKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> q == ($past(wdata) & WMASK)); // R6
    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q)); // R7
endmodule

// File: rtl/perf_counter_bank.sv
// Module: machine-mode performance counter bank. Slot 0 counts cycles, slot 2
// counts retire pulses, slots 3+ count a selected event line. A stop register
// freezes counters and a delegation register records lower-privilege reads.
// Assumes: CNT_W >= 2**SLOT_W; slot 1 (real time) lives elsewhere and reads zero.
module perf_counter_bank
    import pcb_pkg::*;
#(
    parameter int SLOT_W = 5,
    parameter int CNT_W  = 64,
    parameter int EVT_W  = 4,
    parameter bit HAS_BASE = 1'b1,
    parameter bit HAS_PROG = 1'b1,
    parameter logic [(1<<SLOT_W)-1:0] IMPL_MASK = 32'h0000_0078,
    parameter logic [(1<<SLOT_W)-1:0] STOP_ALLOW = '1,
    parameter logic [(1<<SLOT_W)-1:0] DELEG_ALLOW = 32'hFFFF_FFEF,
    parameter logic [(1<<EVT_W)-1:0]  LEGAL_EVT = 16'h00BF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [(1<<EVT_W)-1:0]     event_vec,
    input  logic                      retire,
    input  logic                      csr_we,
    input  logic [SLOT_W+1:0]         csr_addr,
    input  logic [CNT_W-1:0]          csr_wdata,
    output logic [CNT_W-1:0]          csr_rdata
);
    localparam int NUM_SLOTS = 1 << SLOT_W;

    // Purpose: compute which slots hold a real counter.
    function automatic logic [NUM_SLOTS-1:0] f_present();
        logic [NUM_SLOTS-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (i == SLOT_CYCLE || i == SLOT_RETIRE) m[i] = HAS_BASE;
            else if (i >= FIRST_PROG)                m[i] = HAS_PROG && IMPL_MASK[i];
        end
        return m;
    endfunction

    // Purpose: compute the writable delegation bits.
    function automatic logic [NUM_SLOTS-1:0] f_deleg_mask();
        logic [NUM_SLOTS-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (i < FIRST_PROG) m[i] = HAS_BASE && DELEG_ALLOW[i];
            else                m[i] = HAS_PROG && IMPL_MASK[i] && DELEG_ALLOW[i];
        end
        return m;
    endfunction

    localparam logic [NUM_SLOTS-1:0] PRESENT    = f_present();
    localparam logic [NUM_SLOTS-1:0] STOP_MASK  = PRESENT & STOP_ALLOW & ~(NUM_SLOTS'(1) << SLOT_RTC);
    localparam logic [NUM_SLOTS-1:0] DELEG_MASK = f_deleg_mask();

    region_e              region;
    logic [SLOT_W-1:0]    idx;
    logic                 code_in_range;
    logic [NUM_SLOTS-1:0] stop_q;
    logic [NUM_SLOTS-1:0] deleg_q;
    logic [CNT_W-1:0]     cnt_arr [NUM_SLOTS];
    logic [EVT_W-1:0]     sel_arr [NUM_SLOTS];

    // Purpose: split the CSR address into region and slot index.
    always_comb begin
        region = region_e'(csr_addr[SLOT_W+1:SLOT_W]);
        idx    = csr_addr[SLOT_W-1:0];
        code_in_range = (csr_wdata >> EVT_W) == '0;
    end

    pcb_mask_reg #(.W(NUM_SLOTS), .WMASK(STOP_MASK)) u_stop (
        .clk(clk), .rst_n(rst_n),
        .we(csr_we && region == RG_CTL && idx == SLOT_W'(CTL_STOP)),
        .wdata(csr_wdata[NUM_SLOTS-1:0]), .q(stop_q)
    );

    pcb_mask_reg #(.W(NUM_SLOTS), .WMASK(DELEG_MASK)) u_deleg (
        .clk(clk), .rst_n(rst_n),
        .we(csr_we && region == RG_CTL && idx == SLOT_W'(CTL_DELEG)),
        .wdata(csr_wdata[NUM_SLOTS-1:0]), .q(deleg_q)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        if (PRESENT[g]) begin : g_cnt
            logic src;
            if (g == SLOT_CYCLE) begin : g_cyc
                assign src = 1'b1;
            end else if (g == SLOT_RETIRE) begin : g_ret
                assign src = retire;
            end else begin : g_evt
                assign src = (sel_arr[g] != '0) && event_vec[sel_arr[g]];
            end
            pcb_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk(clk), .rst_n(rst_n),
                .inc(src && !stop_q[g]),
                .we(csr_we && region == RG_CNT && idx == SLOT_W'(g)),
                .wdata(csr_wdata), .cnt(cnt_arr[g])
            );
        end else begin : g_nocnt
            assign cnt_arr[g] = '0;
        end

        if (PRESENT[g] && g >= FIRST_PROG) begin : g_sel
            pcb_evsel #(.EVT_W(EVT_W), .LEGAL(LEGAL_EVT)) u_sel (
                .clk(clk), .rst_n(rst_n),
                .we(csr_we && region == RG_SEL && idx == SLOT_W'(g)),
                .in_range(code_in_range),
                .code(csr_wdata[EVT_W-1:0]), .sel(sel_arr[g])
            );
        end else begin : g_nosel
            assign sel_arr[g] = '0;
        end
    end

    // Purpose: combinational read mux over all regions.
    always_comb begin
        csr_rdata = '0;
        unique case (region)
            RG_CNT: csr_rdata = cnt_arr[idx];
            RG_SEL: csr_rdata[EVT_W-1:0] = sel_arr[idx];
            RG_CTL: begin
                if (idx == SLOT_W'(CTL_STOP))       csr_rdata[NUM_SLOTS-1:0] = stop_q;
                else if (idx == SLOT_W'(CTL_DELEG)) csr_rdata[NUM_SLOTS-1:0] = deleg_q;
            end
            default: csr_rdata = '0;
        endcase
    end

    AST_STOP_BIT1_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_CTL && idx == SLOT_W'(CTL_STOP)) |-> csr_rdata[SLOT_RTC] == 1'b0); // R6
    AST_ABSENT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((region == RG_CNT || region == RG_SEL) && !PRESENT[idx]) |-> csr_rdata == '0); // R9

    if (PRESENT[SLOT_CYCLE]) begin : g_cyc_chk
        AST_STOP_FREEZES_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_q[SLOT_CYCLE] && !(csr_we && region == RG_CNT && idx == SLOT_W'(SLOT_CYCLE)))
            |=> $stable(cnt_arr[SLOT_CYCLE])); // R2
    end
endmodule

// File: tb/perf_counter_bank_bench.sv
`timescale 1ns/1ps
module perf_counter_bank_bench;
    localparam int CNT_W = 64;
    localparam logic [1:0] RC = 2'd0, RS = 2'd1, RT = 2'd2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       event_vec = '0;
    logic              retire = 1'b0;
    logic              csr_we = 1'b0;
    logic [6:0]        csr_addr = '0;
    logic [CNT_W-1:0]  csr_wdata = '0;
    logic [CNT_W-1:0]  csr_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done = 1'b0;

    typedef struct {
        logic [CNT_W-1:0] exp;
        string            tag;
    } sb_item_t;
    sb_item_t sb_q[$];
    event sample_ev;

    always #2.5 clk = ~clk;

    perf_counter_bank u_perf_counter_bank (
        .clk(clk), .rst_n(rst_n), .event_vec(event_vec), .retire(retire),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata)
    );

    function automatic logic [6:0] ad(logic [1:0] r, int s);
        return {r, 5'(s)};
    endfunction

    // Driver: one-clock write, returns at the falling edge after the write edge.
    task automatic wr(logic [6:0] a, logic [CNT_W-1:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    // Driver: present a read address now and push the expected value.
    task automatic rd(logic [6:0] a, logic [CNT_W-1:0] e, string tag);
        sb_item_t it;
        csr_addr = a;
        #1;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        -> sample_ev;
        #0.1;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop expected items and compare against the read port.
    initial begin
        forever begin
            @(sample_ev);
            #0;
            while (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                n_tests++;
                if (csr_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got 0x%0h expected 0x%0h", it.tag, csr_rdata, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(ad(RC,0), 0, "R1 cycle");
        rd(ad(RC,2), 0, "R1 retire");
        rd(ad(RC,3), 0, "R1 slot3");
        rd(ad(RS,3), 0, "R1 sel3");
        rd(ad(RT,0), 0, "R1 stop");
        rd(ad(RT,1), 0, "R1 deleg");

        // R8 write wins, R2 counting
        wr(ad(RC,0), 1000);
        rd(ad(RC,0), 1000, "R8 cycle load");
        idle(5);
        rd(ad(RC,0), 1005, "R2 cycle count");
        wr(ad(RT,0), 1);
        wr(ad(RC,0), 50);
        rd(ad(RC,0), 50, "R2 stopped");
        idle(4);
        rd(ad(RC,0), 50, "R2 stays stopped");
        wr(ad(RT,0), 0);
        rd(ad(RC,0), 50, "R2 resume edge");
        idle(3);
        rd(ad(RC,0), 53, "R2 resumed");

        // R3 retire counter
        @(negedge clk); retire = 1'b1;
        idle(6); retire = 1'b0;
        rd(ad(RC,2), 6, "R3 retire count");
        wr(ad(RT,0), 4);
        @(negedge clk); retire = 1'b1;
        idle(3); retire = 1'b0;
        rd(ad(RC,2), 6, "R3 retire stopped");
        wr(ad(RT,0), 0);

        // R4/R5 programmable slot 3
        wr(ad(RS,3), 2);
        rd(ad(RS,3), 2, "R5 legal code");
        @(negedge clk); event_vec = 16'h0024;
        idle(4); event_vec = '0;
        rd(ad(RC,3), 4, "R4 event count");
        wr(ad(RS,3), 6);
        rd(ad(RS,3), 2, "R5 code 6 rejected");
        wr(ad(RS,3), 9);
        rd(ad(RS,3), 2, "R5 code 9 rejected");
        wr(ad(RS,3), 64'h12);
        rd(ad(RS,3), 2, "R5 out of range rejected");
        wr(ad(RS,3), 0);
        rd(ad(RS,3), 0, "R5 code 0 accepted");
        @(negedge clk); event_vec = 16'hFFFF;
        idle(3); event_vec = '0;
        rd(ad(RC,3), 4, "R4 code 0 counts nothing");

        // R2 stop on a programmable slot
        wr(ad(RS,4), 7);
        wr(ad(RT,0), 64'h10);
        @(negedge clk); event_vec = 16'h0080;
        idle(3); event_vec = '0;
        rd(ad(RC,4), 0, "R2 slot4 stopped");
        wr(ad(RT,0), 0);
        @(negedge clk); event_vec = 16'h0080;
        idle(2); event_vec = '0;
        rd(ad(RC,4), 2, "R4 slot4 code 7");

        // R8 priority under event, R10 wrap
        wr(ad(RS,5), 1);
        event_vec = 16'h0002;
        wr(ad(RC,5), '1);
        rd(ad(RC,5), '1, "R8 write beats event");
        @(negedge clk); event_vec = '0;
        rd(ad(RC,5), 0, "R10 wrap");

        // R6/R7 masks
        wr(ad(RT,0), '1);
        rd(ad(RT,0), 64'h7D, "R6 stop mask");
        wr(ad(RT,0), 0);
        wr(ad(RT,1), '1);
        rd(ad(RT,1), 64'h6F, "R7 deleg mask");
        wr(ad(RT,1), 0);
        rd(ad(RT,1), 0, "R7 deleg cleared");

        // R9 absent slots
        wr(ad(RC,10), 123);
        rd(ad(RC,10), 0, "R9 absent counter");
        wr(ad(RS,10), 1);
        rd(ad(RS,10), 0, "R9 absent selector");
        wr(ad(RC,1), 77);
        rd(ad(RC,1), 0, "R9 slot1 reads zero");
        wr(ad(RS,7), 2);
        rd(ad(RS,7), 0, "R9 slot7 selector");

        idle(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule